// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small 32-bit processor that completes one instruction per clock. It runs an integer subset made of three instruction shapes:

- **Register shape:** three-register arithmetic and compare.
- **Immediate shape:** a register, a destination and a 16-bit constant, used for loads, stores, immediate arithmetic and conditional branches.
- **Jump shape:** a 26-bit word index.

The core holds the program counter, decode, a register file with a hardwired zero entry, an ALU and the next-address logic.

Instruction fetch and data access leave the block as two plain memory ports. Both memories answer in the same cycle: read data must be valid within the cycle that presents the address, and a store is committed by the memory on the rising clock edge while `dmem_we` is high. The two ports carry no handshake and no back-pressure. A memory that cannot answer in the same cycle must hold the core's clock.

In a typical use, a program is placed in the instruction store and data in the data store, then reset is released. Results are read back from data memory after the program has parked itself on a jump to its own address.

Top module: `scalar_core`

## Requirements
- R1: A synchronous, active-high reset forces the program counter to 0 and every register to 0, and keeps `dmem_we` low while reset is held.
- R2: Any instruction that is not a branch or jump advances the program counter by 4.
- R3: Opcode 0 with funct 32 adds and funct 34 subtracts `rs` and `rt` into `rd`. Funct 42 writes 1 to `rd` when `rs` < `rt` as signed two's-complement numbers, and 0 otherwise. In this shape the bit fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R4: Opcodes 8 (add) and 10 (signed set-less-than) sign-extend imm[15:0]. Opcodes 12 (and) and 13 (or) zero-extend it. Each writes its result to `rt`.
- R5: Opcode 15 writes imm[15:0] to the upper half of `rt` and clears the lower half.
- R6: Opcode 35 loads the word at byte address `rs` plus the sign-extended offset into `rt`. Opcode 43 raises `dmem_we` and presents `rt` as the data at that same address. `dmem_we` is high for no other instruction.
- R7: Opcode 4 (operands equal) and opcode 5 (operands different) branch to PC+4 plus the sign-extended offset shifted left by 2 when their condition holds. Otherwise they fall through to PC+4.
- R8: Opcode 2 jumps to {PC+4[31:28], field[25:0], 2'b00}.
- R9: Register 0 always reads as 0. A write aimed at it is discarded.
- R10: Any other opcode, or opcode 0 with any other funct, writes no register and no memory, and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Word to be stored |
| dmem_we | output | 1 | Store strobe, committed on the next rising edge |
| dmem_rdata | input | 32 | Word at `dmem_addr`, valid in the same cycle |

## Verification
Two functions share every clock edge:

- the register write-back of one instruction, and
- the operand read of the next instruction, which is decided in the cycle right after.

The test program provokes this sharing repeatedly. A count-down loop has its branch test the register that the previous instruction just decremented. A load takes its base address from an add committed one edge earlier. A store of a swapped word reads the register loaded one cycle before.

A behavioural reference model in the bench steps the same program. Every cycle, it judges the program counter and the store strobe, address and data against the model. Once the program has parked, it checks the final data words against values worked out by hand.

// File: rtl/core_pkg.sv
package core_pkg;

  // primary opcodes
  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;
  localparam logic [5:0] OPC_LW   = 6'd35;
  localparam logic [5:0] OPC_SW   = 6'd43;

  // function codes of the register shape
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_HI
  } alu_op_e;

  typedef enum logic [1:0] {
    NPC_SEQ,
    NPC_BEQ,
    NPC_BNE,
    NPC_JMP
  } npc_sel_e;

  typedef struct packed {
    logic     known;     // encoding recognised
    logic     reg_we;    // result goes to the register file
    logic     dst_rd;    // destination is rd (else rt)
    logic     src_imm;   // ALU second operand is the immediate
    logic     imm_zext;  // zero-extend the immediate (else sign-extend)
    logic     load;      // write-back takes memory data
    logic     store;     // raise the store strobe
    alu_op_e  alu_op;
    npc_sel_e npc_sel;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.alu_op  = ALU_ADD;
    ctrl.npc_sel = NPC_SEQ;
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_SLT: begin ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ;
        endcase
      end
      OPC_ADDI: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.alu_op = ALU_ADD;
      end
      OPC_SLTI: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.alu_op = ALU_SLT;
      end
      OPC_ANDI: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_AND;
      end
      OPC_ORI: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OPC_LUI: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_HI;
      end
      OPC_LW: begin
        ctrl.known = 1'b1; ctrl.reg_we = 1'b1; ctrl.src_imm = 1'b1;
        ctrl.load = 1'b1; ctrl.alu_op = ALU_ADD;
      end
      OPC_SW: begin
        ctrl.known = 1'b1; ctrl.src_imm = 1'b1; ctrl.store = 1'b1;
        ctrl.alu_op = ALU_ADD;
      end
      OPC_BEQ: begin ctrl.known = 1'b1; ctrl.npc_sel = NPC_BEQ; end
      OPC_BNE: begin ctrl.known = 1'b1; ctrl.npc_sel = NPC_BNE; end
      OPC_JMP: begin ctrl.known = 1'b1; ctrl.npc_sel = NPC_JMP; end
      default: ;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] ra_addr,
  output logic [WIDTH-1:0]        ra_data,
  input  logic [$clog2(NREG)-1:0] rb_addr,
  output logic [WIDTH-1:0]        rb_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_addr,
  input  logic [WIDTH-1:0]        wr_data
);

  localparam int unsigned AW = $clog2(NREG);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic [WIDTH-1:0] cells [NREG];

  // entry 0 is cleared by reset and never written afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREG); i++) cells[i] <= '0;
    end else if (wr_en && (wr_addr != ZERO_IDX)) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign ra_data = (ra_addr == ZERO_IDX) ? '0 : cells[ra_addr];
  assign rb_data = (rb_addr == ZERO_IDX) ? '0 : cells[rb_addr];

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  localparam int unsigned HALF = WIDTH / 2;

  logic less;
  assign less = ($signed(a) < $signed(b));

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, less};
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_HI:  y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/core_pc_next.sv
module core_pc_next
  import core_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned OFFW  = 16,
  parameter int unsigned JFW   = 26
) (
  input  npc_sel_e         sel,
  input  logic [WIDTH-1:0] pc,
  input  logic [OFFW-1:0]  offset,
  input  logic [JFW-1:0]   jfield,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] pc_nxt
);

  localparam int unsigned EXTW = WIDTH - OFFW - 2;
  localparam int unsigned KEEP = WIDTH - JFW - 2;

  logic [WIDTH-1:0] seq, br_tgt, jmp_tgt;
  logic             same;

  assign seq     = pc + WIDTH'(4);
  assign br_tgt  = seq + {{EXTW{offset[OFFW-1]}}, offset, 2'b00};
  assign jmp_tgt = {seq[WIDTH-1 -: KEEP], jfield, 2'b00};
  assign same    = (opa == opb);

  always_comb begin
    unique case (sel)
      NPC_BEQ: pc_nxt = same  ? br_tgt : seq;
      NPC_BNE: pc_nxt = !same ? br_tgt : seq;
      NPC_JMP: pc_nxt = jmp_tgt;
      default: pc_nxt = seq;
    endcase
  end

endmodule

// File: rtl/scalar_core.sv
module scalar_core
  import core_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int unsigned RAW  = $clog2(NREG);
  localparam int unsigned IMMW = 16;
  localparam int unsigned JFW  = 26;
  localparam int unsigned EXTW = XLEN - IMMW;

  logic [XLEN-1:0] pc_q, pc_d;

  logic [5:0]      f_op, f_fn;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [IMMW-1:0] f_imm;
  logic [JFW-1:0]  f_jf;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[21 +: RAW];
  assign f_rt  = imem_data[16 +: RAW];
  assign f_rd  = imem_data[11 +: RAW];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[IMMW-1:0];
  assign f_jf  = imem_data[JFW-1:0];

  ctrl_t ctrl;

  core_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  logic [XLEN-1:0] rs_val, rt_val, wb_data, imm_ext, alu_b, alu_y;
  logic [RAW-1:0]  wb_addr;
  logic            rf_we;

  assign rf_we   = ctrl.reg_we && !rst;
  assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctrl.load ? dmem_rdata : alu_y;

  core_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_addr (f_rs),
    .ra_data (rs_val),
    .rb_addr (f_rt),
    .rb_data (rt_val),
    .wr_en   (rf_we),
    .wr_addr (wb_addr),
    .wr_data (wb_data)
  );

  assign imm_ext = ctrl.imm_zext ? {{EXTW{1'b0}}, f_imm}
                                 : {{EXTW{f_imm[IMMW-1]}}, f_imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  core_alu #(.WIDTH(XLEN)) u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  core_pc_next #(.WIDTH(XLEN), .OFFW(IMMW), .JFW(JFW)) u_npc (
    .sel    (ctrl.npc_sel),
    .pc     (pc_q),
    .offset (f_imm),
    .jfield (f_jf),
    .opa    (rs_val),
    .opb    (rt_val),
    .pc_nxt (pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[XLEN-1:0];
    else     pc_q <= pc_d;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.store && !rst;

  // R1: reset parks the program counter
  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == RESET_PC[XLEN-1:0]));

  // R2: straight-line code steps one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl.npc_sel == NPC_SEQ) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R3: set-less-than yields a single bit
  p_slt_bool_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

  // R5: upper-immediate leaves the low half clear
  p_hi_low_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_LUI) |-> (wb_data[IMMW-1:0] == '0));

  // R6: store strobe only for the store opcode
  p_store_only_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_data[31:26] == OPC_SW));

  // R7: an equal-branch with differing operands falls through
  p_beq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    ((f_op == OPC_BEQ) && (rs_val != rt_val)) |=>
      (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R8: jump lands on the word index given by the field
  p_jump_field_r8: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_JMP) |=> (imem_addr[JFW+1:2] == $past(imem_data[JFW-1:0])));

  // R10: unrecognised encodings touch neither store nor registers
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl.known |-> (!dmem_we && !rf_we));

endmodule

// File: tb/test_scalar_core.sv
`timescale 1ns/1ps
module test_scalar_core;

  localparam int MW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] im [MW];
  logic [31:0] dm [MW];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scalar_core i_scalar_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = im[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] e_r(input int fn, rs, rt, rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] e_i(input int op, rs, rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] e_j(input int idx);
    return {6'd2, 26'(idx)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mr [32];
  logic [31:0] mm [MW];
  logic [31:0] mpc;

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'd0:  return (fn == 6'd32 || fn == 6'd34 || fn == 6'd42) ? "R3" : "R10";
      6'd35, 6'd43: return "R6";
      6'd4, 6'd5:   return "R7";
      6'd2:  return "R8";
      6'd8, 6'd10, 6'd12, 6'd13: return "R4";
      6'd15: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] ins, a, b, sx, zx, npc, res, ea;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, dst;
    logic        wr, st;
    string       t;
    ins = im[mpc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    a = mr[rs]; b = mr[rt];
    npc = mpc + 32'd4; wr = 0; st = 0; res = '0; dst = rt; ea = a + sx;
    t = tag_of(op, fn);
    case (op)
      6'd0: begin
        dst = rd;
        case (fn)
          6'd32: begin wr = 1; res = a + b; end
          6'd34: begin wr = 1; res = a - b; end
          6'd42: begin wr = 1; res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
          default: ;
        endcase
      end
      6'd35: begin wr = 1; res = mm[ea[7:2]]; end
      6'd43: st = 1;
      6'd4:  if (a == b) npc = mpc + 32'd4 + (sx << 2);
      6'd5:  if (a != b) npc = mpc + 32'd4 + (sx << 2);
      6'd2:  npc = {npc[31:28], ins[25:0], 2'b00};
      6'd8:  begin wr = 1; res = a + sx; end
      6'd10: begin wr = 1; res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
      6'd12: begin wr = 1; res = a & zx; end
      6'd13: begin wr = 1; res = a | zx; end
      6'd15: begin wr = 1; res = {ins[15:0], 16'd0}; end
      default: ;
    endcase
    chk("R2", "pc", imem_addr, mpc);
    chk(t, "store strobe", {31'd0, dmem_we}, {31'd0, st});
    if (st) begin
      chk(t, "store addr", dmem_addr, ea);
      chk(t, "store data", dmem_wdata, b);
      mm[ea[7:2]] = b;
    end
    if (wr && dst != 5'd0) mr[dst] = res;
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < MW; i++) begin
      im[i] = '0;
      dm[i] = 32'hDEAD0000 + 32'(i);
    end
    dm[0] = 32'd11;
    dm[1] = 32'd22;
    im[0]  = e_i(35, 0, 2, 16'd0);
    im[1]  = e_i(35, 0, 3, 16'd4);
    im[2]  = e_i(43, 0, 3, 16'd0);
    im[3]  = e_i(43, 0, 2, 16'd4);
    im[4]  = e_i(15, 0, 4, 16'hABCD);
    im[5]  = e_i(13, 4, 4, 16'h1234);
    im[6]  = e_i(43, 0, 4, 16'd8);
    im[7]  = e_i(8, 0, 5, 16'hFFFB);
    im[8]  = e_r(42, 5, 2, 6);
    im[9]  = e_i(10, 5, 7, 16'hFFFA);
    im[10] = e_i(12, 5, 8, 16'hFFFF);
    im[11] = e_r(34, 2, 3, 9);
    im[12] = e_r(32, 2, 3, 0);
    im[13] = e_i(43, 0, 0, 16'd12);
    im[14] = e_i(4, 2, 3, 16'd2);
    im[15] = e_i(5, 2, 3, 16'd1);
    im[16] = e_i(8, 0, 10, 16'd99);
    im[17] = e_i(8, 0, 11, 16'd3);
    im[18] = e_i(8, 11, 11, 16'hFFFF);
    im[19] = e_i(5, 11, 0, 16'hFFFE);
    im[20] = e_i(43, 0, 5, 16'd16);
    im[21] = e_i(43, 0, 6, 16'd20);
    im[22] = e_i(43, 0, 7, 16'd24);
    im[23] = e_i(43, 0, 8, 16'd28);
    im[24] = e_i(43, 0, 9, 16'd32);
    im[25] = e_i(43, 0, 10, 16'd36);
    im[26] = e_i(43, 0, 11, 16'd40);
    im[27] = e_j(29);
    im[28] = e_i(8, 0, 12, 16'd7);
    im[29] = e_i(43, 0, 12, 16'd44);
    im[30] = e_i(10, 5, 13, 16'd0);
    im[31] = e_i(4, 0, 0, 16'd1);
    im[32] = e_i(8, 0, 13, 16'd5);
    im[33] = e_i(43, 0, 13, 16'd48);
    im[34] = 32'hFC000000;
    im[35] = e_i(8, 0, 15, 16'd8);
    im[36] = e_i(35, 15, 14, 16'hFFFC);
    im[37] = e_i(43, 0, 14, 16'd52);
    im[38] = e_j(38);
    for (int i = 0; i < 32; i++) mr[i] = '0;
    for (int i = 0; i < MW; i++) mm[i] = dm[i];
    mpc = '0;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'd0);
    chk("R1", "strobe in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    #1;
    for (int c = 0; c < 60; c++) begin
      model_step();
      @(negedge clk);
    end
    chk("R8", "parked pc", imem_addr, 32'h98);
    chk("R6", "swap word0", dm[0], 32'd22);
    chk("R6", "swap word1", dm[1], 32'd11);
    chk("R5", "upper+or", dm[2], 32'hABCD1234);
    chk("R9", "zero reg store", dm[3], 32'd0);
    chk("R4", "addi negative", dm[4], 32'hFFFFFFFB);
    chk("R3", "slt signed", dm[5], 32'd1);
    chk("R4", "slti signed", dm[6], 32'd0);
    chk("R4", "andi zero-ext", dm[7], 32'h0000FFFB);
    chk("R3", "sub", dm[8], 32'hFFFFFFF5);
    chk("R7", "bne skip", dm[9], 32'd0);
    chk("R7", "loop count", dm[10], 32'd0);
    chk("R8", "jump skip", dm[11], 32'd0);
    chk("R7", "beq taken", dm[12], 32'd1);
    chk("R6", "negative offset load", dm[13], 32'd11);
    chk("R10", "untouched word", dm[14], 32'hDEAD000E);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule